// File: doc/BRIEF.md
# Oversampled SPI Frame Receiver

This block accepts fixed-length serial words from a second device over three wires: an active-low select, a serial clock and one data line. Nothing in the block runs on the link clock. All three wires are treated as asynchronous data. They are brought into the local system clock domain through a synchroniser. A single extra register stage then turns level changes into one-cycle edge pulses. Every flip-flop in the block uses the rising edge of the one system clock.

A frame opens when select falls. Each detected rising edge of the serial clock shifts one data bit into a register, least significant bit first. When select rises, the frame closes. If exactly the frame length was captured, the word is published with a one-cycle valid strobe, and the upper byte is copied to a display port. Any other bit count throws the frame away and pulses an error flag. The sender must hold each serial-clock level for at least one system-clock period.

The control state machine has three states. `ST_IDLE` waits with select high. `ST_RECV` collects bits. `ST_OVER` marks a frame that received more clock edges than the frame length. Its transitions are:
- `ST_IDLE` to `ST_RECV` on a select fall.
- `ST_RECV` to `ST_IDLE` on a select rise, which either publishes the word or flags an error.
- `ST_RECV` to `ST_OVER` on a serial-clock rise when the frame is already full.
- `ST_OVER` to `ST_IDLE` on a select rise, which flags an error.

Top module: `spirx_frame_rx`

## Requirements
- R1: While synchronous reset is high, and after it is released with select high, `word_o` is 0, `led_o` is 0, and `word_vld_o` and `frame_err_o` are 0.
- R2: A frame of exactly 16 serial-clock rises between a select fall and a select rise is published on `word_o`. The first bit sent lands in bit 0 and the last in bit 15. `word_vld_o` is high in the 3rd system-clock cycle after select rises on the pin.
- R3: Each bit takes the data-line value present when the serial-clock rise reaches the pin. Data changes while the serial clock is low between bits have no effect on the word.
- R4: A frame with fewer than 16 rises, including zero, pulses `frame_err_o` in the 3rd cycle after select rises. `word_o` keeps its previous value.
- R5: A frame with more than 16 rises pulses `frame_err_o` in the 3rd cycle after select rises. `word_o` keeps its previous value.
- R6: `led_o` always equals bits 15..8 of the most recently published word. An errored frame does not change it.
- R7: `word_vld_o` and `frame_err_o` each last exactly one cycle per frame, and they are never high together.
- R8: A select fall restarts the bit count and clears the shift register, so a good frame that follows an errored frame is decoded correctly.
- R9: Serial-clock and data activity while select is high produces no strobe, no error and no change to `word_o` or `led_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz, rising edge only |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_i | input | 1 | Asynchronous frame select from the link, active low |
| sck_i | input | 1 | Asynchronous serial clock from the link, sampled as data |
| sdi_i | input | 1 | Asynchronous serial data from the link |
| word_o | output | 16 | Last published word |
| word_vld_o | output | 1 | One-cycle strobe when `word_o` is updated |
| frame_err_o | output | 1 | One-cycle pulse when a frame is discarded |
| led_o | output | 8 | Upper byte of the last published word, for display |

## Verification
The end of a frame passes through three registers before it becomes visible: two synchroniser flops and the registered output stage. The reference model in the bench therefore schedules each expected strobe or error for the 3rd cycle after the edge at which select is driven high. It keeps those expectations in a queue indexed by an absolute cycle count. Outputs are compared at every falling clock edge against that schedule: strobe, error, word and display byte. An early, late, doubled or missing pulse is therefore caught in the exact cycle it occurs.

// File: rtl/spirx_pkg.sv
package spirx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_OVER = 2'd2
    } rx_state_e;

endpackage

// File: rtl/spirx_sync.sv
// Multi-flop synchroniser for a vector of unrelated asynchronous wires.
module spirx_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] pipe_q;

        always_ff @(posedge clk) begin
            if (rst) pipe_q <= {STAGES{RST_VAL[g]}};
            else     pipe_q <= {pipe_q[STAGES-2:0], async_i[g]};
        end

        assign sync_o[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/spirx_delay.sv
// One register stage holding the previous synchronised sample for edge detection.
module spirx_delay #(
    parameter int         WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= RST_VAL;
        else     q_o <= d_i;
    end

endmodule

// File: rtl/spirx_shift.sv
// LSB-first shift register with a bit counter.
module spirx_shift #(
    parameter int BITS  = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [BITS-1:0]  word_o,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            word_o <= '0;
            cnt_o  <= '0;
        end else if (en_i) begin
            word_o <= {bit_i, word_o[BITS-1:1]};
            cnt_o  <= cnt_o + 1'b1;
        end
    end

    // R5: the counter never passes the frame length, extra rises are not shifted
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= CNT_W'(BITS));

    // R8: a clear leaves an empty frame behind
    a_r8_clear_empty: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/spirx_frame_rx.sv
module spirx_frame_rx
    import spirx_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int LED_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n_i,
    input  logic                  sck_i,
    input  logic                  sdi_i,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  word_vld_o,
    output logic                  frame_err_o,
    output logic [LED_BITS-1:0]   led_o
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    // index 0: select, 1: serial clock, 2: data
    logic [2:0] sync_s;
    logic [1:0] prev_s;

    spirx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i({sdi_i, sck_i, cs_n_i}),
        .sync_o (sync_s)
    );

    spirx_delay #(
        .WIDTH  (2),
        .RST_VAL(2'b01)
    ) u_prev (
        .clk(clk),
        .rst(rst),
        .d_i(sync_s[1:0]),
        .q_o(prev_s)
    );

    logic cs_fall, cs_rise, sck_rise;
    assign cs_fall  = prev_s[0]  & ~sync_s[0];
    assign cs_rise  = ~prev_s[0] &  sync_s[0];
    assign sck_rise = ~prev_s[1] &  sync_s[1];

    rx_state_e state_q, state_d;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  shift_en;

    assign shift_en = sck_rise && (state_q == ST_RECV) && (bit_cnt != FULL);

    spirx_shift #(
        .BITS (FRAME_BITS),
        .CNT_W(CNT_W)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cs_fall),
        .en_i  (shift_en),
        .bit_i (sync_s[2]),
        .word_o(shreg),
        .cnt_o (bit_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall) state_d = ST_RECV;
            ST_RECV: begin
                if (cs_rise)                            state_d = ST_IDLE;
                else if (sck_rise && bit_cnt == FULL)   state_d = ST_OVER;
            end
            ST_OVER: if (cs_rise) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o      <= '0;
            led_o       <= '0;
            word_vld_o  <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            word_vld_o  <= 1'b0;
            frame_err_o <= 1'b0;
            if (cs_rise && state_q == ST_RECV && bit_cnt == FULL) begin
                word_o     <= shreg;
                led_o      <= shreg[FRAME_BITS-1 -: LED_BITS];
                word_vld_o <= 1'b1;
            end else if (cs_rise && state_q != ST_IDLE) begin
                frame_err_o <= 1'b1;
            end
        end
    end

    a_r7_vld_single: assert property (@(posedge clk) disable iff (rst)
        word_vld_o |=> !word_vld_o);

    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> !frame_err_o);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(word_vld_o && frame_err_o));

    a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(word_o) |-> word_vld_o);

    a_r6_led_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(led_o) |-> word_vld_o);

    a_r5_over_full: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVER) |-> (bit_cnt == FULL));

    a_r9_idle_empty: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> !(shift_en));

endmodule

// File: tb/sim_spirx_frame_rx.sv
module sim_spirx_frame_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [15:0] word_o;
    logic        word_vld_o, frame_err_o;
    logic [7:0]  led_o;

    always #10 clk = ~clk;   // 50 MHz

    spirx_frame_rx u0 (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (cs_n),
        .sck_i      (sck),
        .sdi_i      (sdi),
        .word_o     (word_o),
        .word_vld_o (word_vld_o),
        .frame_err_o(frame_err_o),
        .led_o      (led_o)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    string cur_req = "R1";

    // reference model: scheduled events by absolute cycle
    int          due_q[$];
    bit          good_q[$];
    logic [15:0] wq[$];
    logic [15:0] exp_word = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h cyc=%0d", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (cyc >= 1) begin
            logic ev, eerr;
            ev = 1'b0;
            eerr = 1'b0;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                if (good_q[0]) begin
                    ev = 1'b1;
                    exp_word = wq[0];
                end else begin
                    eerr = 1'b1;
                end
                void'(due_q.pop_front());
                void'(good_q.pop_front());
                void'(wq.pop_front());
            end
            chk("R7", "vld", {31'd0, word_vld_o}, {31'd0, ev});
            chk(cur_req, "err", {31'd0, frame_err_o}, {31'd0, eerr});
            chk(cur_req, "word", {16'd0, word_o}, {16'd0, exp_word});
            chk("R6", "led", {24'd0, led_o}, {24'd0, exp_word[15:8]});
        end
    end

    // Sends n bits of w (bit i of the stream is w[i mod 16]), four phases per bit.
    task automatic send_frame(input logic [15:0] w, input int n, input bit noisy);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        if (n == 0) begin
            cs_n = 1'b1;
            due_q.push_back(cyc + 3); good_q.push_back(1'b0); wq.push_back(w);
        end
        for (int i = 0; i < n; i++) begin
            sdi = w[i % 16];
            @(negedge clk);
            sck = 1'b1;
            @(negedge clk);
            sck = 1'b0;
            if (i == n - 1) begin
                cs_n = 1'b1;
                due_q.push_back(cyc + 3);
                good_q.push_back(n == 16);
                wq.push_back(w);
            end
            @(negedge clk);
            if (noisy) sdi = ~w[i % 16];
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        cur_req = "R2";
        send_frame(16'hA5C3, 16, 1'b0);
        send_frame(16'h0001, 16, 1'b0);
        send_frame(16'h8000, 16, 1'b0);

        cur_req = "R3";
        send_frame(16'h3C96, 16, 1'b1);

        cur_req = "R4";
        send_frame(16'h7FFF, 5, 1'b0);
        send_frame(16'h1111, 0, 1'b0);

        cur_req = "R8";
        send_frame(16'h1234, 16, 1'b0);

        cur_req = "R5";
        send_frame(16'hF00F, 17, 1'b0);
        send_frame(16'hFFFF, 16, 1'b0);

        cur_req = "R9";
        for (int k = 0; k < 8; k++) begin
            sdi = k[0];
            @(negedge clk); sck = 1'b1;
            @(negedge clk); sck = 1'b0;
            @(negedge clk);
        end
        repeat (8) @(negedge clk);

        cur_req = "R8";
        send_frame(16'h5A69, 16, 1'b1);
        repeat (4) @(negedge clk);
        chk("R2", "queue drained", due_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule